// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits beside a UART and handles in-band flow control with XON and XOFF characters. It compares the receive buffer fill level with two programmable thresholds and, when the level climbs above the upper one or falls below the lower one, asks the transmitter to insert the matching control character. Software can also demand either character at any time through two request bits that clear themselves once the character has been taken. On the receive side, every byte that arrives is compared with the two programmed codes. A matching XOFF halts the local transmit stream until a matching XON arrives, and each match raises a sticky interrupt flag.

The control character leaves the block on a valid/ready channel toward the transmitter. `ctl_valid` rises with `ctl_data` holding the code, and both stay unchanged until the transmitter accepts them with `ctl_ready`. Back-pressure is unlimited: the block waits for as long as `ctl_ready` stays low, and it never offers a second character until the first has been accepted. The normal transmit stream passes through a valid/ready gate. While transmission is halted, the gate forces both the downstream valid and the upstream ready low, so no data beat can complete. The payload itself travels outside the block. Inserted control characters do not pass through this gate, so they still go out while transmission is halted.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `ctl_valid`, both software request bits, both interrupt flags and `tx_paused` are all 0.
- R2: While `cfg_en` is 1 and no XOFF is outstanding, a fill level strictly greater than `cfg_hi_thr` makes `ctl_valid` rise one clock later, with `ctl_data` equal to `cfg_xoff_code`. A level equal to the threshold produces nothing.
- R3: While `cfg_en` is 1 and an XOFF is outstanding, a fill level strictly less than `cfg_lo_thr` makes `ctl_valid` rise one clock later, with `ctl_data` equal to `cfg_xon_code`. A level equal to the threshold produces nothing.
- R4: Once an XOFF is accepted, no automatic XOFF is offered again until an XON has been accepted. Once an XON is accepted, no automatic XON is offered again until an XOFF has been accepted.
- R5: While `ctl_valid` is 1 and `ctl_ready` is 0, `ctl_valid` stays 1 and `ctl_data` holds its value, even if the code fields change. `ctl_valid` falls in the clock after acceptance.
- R6: A pulse on `sw_xon_set` or `sw_xoff_set` sets the matching request bit. The bit causes its character to be offered whatever the value of `cfg_en`, and it clears in the clock in which that character is accepted.
- R7: Software requests win over automatic ones. When both software bits are pending, XOFF is offered first and XON after it.
- R8: While `cfg_en` is 1, a received byte equal to `cfg_xoff_code` sets `tx_paused` in the next clock. A received byte equal to `cfg_xon_code` clears it, and any other byte leaves it unchanged. While `tx_paused` is 1, `tx_out_valid` and `tx_in_ready` are both 0.
- R9: While `cfg_en` is 1, a received XON code sets `irq_xon_raw` and a received XOFF code sets `irq_xoff_raw`. Each flag stays set until a 1 is written to its clear bit: `irq_clr[0]` clears the XON flag and `irq_clr[1]` clears the XOFF flag. A new set in the same clock as a clear wins.
- R10: While `cfg_en` is 0, received bytes set neither the interrupt flags nor `tx_paused`, no automatic character is offered, and `tx_paused` is 0 one clock later.
- R11: While `tx_paused` is 0, `tx_out_valid` equals `tx_in_valid` and `tx_in_ready` equals `tx_out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Enables automatic flow control and receive detection |
| cfg_hi_thr | input | LVL_W | Fill level above which an XOFF is requested |
| cfg_lo_thr | input | LVL_W | Fill level below which an XON is requested |
| cfg_xon_code | input | CHAR_W | XON character code |
| cfg_xoff_code | input | CHAR_W | XOFF character code |
| sw_xon_set | input | 1 | Pulse: set the software XON request |
| sw_xoff_set | input | 1 | Pulse: set the software XOFF request |
| irq_clr | input | 2 | Write-one-to-clear pulse; bit 0 clears the XON flag, bit 1 clears the XOFF flag |
| rx_level | input | LVL_W | Receive buffer fill level |
| rx_byte_valid | input | 1 | Strobe marking a received byte |
| rx_byte | input | CHAR_W | Received byte |
| ctl_valid | output | 1 | A control character is offered |
| ctl_data | output | CHAR_W | Offered control character |
| ctl_ready | input | 1 | Transmitter accepts the control character |
| tx_in_valid | input | 1 | Upstream transmit data valid |
| tx_in_ready | output | 1 | Ready returned upstream |
| tx_out_valid | output | 1 | Valid forwarded to the transmitter |
| tx_out_ready | input | 1 | Ready from the transmitter |
| sw_xon_pend | output | 1 | Software XON request pending |
| sw_xoff_pend | output | 1 | Software XOFF request pending |
| irq_xon_raw | output | 1 | Sticky flag: XON received |
| irq_xoff_raw | output | 1 | Sticky flag: XOFF received |
| tx_paused | output | 1 | Local transmission halted by a received XOFF |

## Verification
Three kinds of collision can happen in the same clock, and the bench provokes each one on purpose. Both software request bits are pulsed together, and the bench expects the XOFF code first and then the XON code on consecutive transfers. A software XON request is left pending while the fill level is raised above the upper threshold, and the bench expects the software XON to be offered before the automatic XOFF. Finally, a received XON byte is strobed in the same clock as a write to clear its interrupt flag, and the bench requires the flag to remain set.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  // Request sources; a lower value means higher priority.
  typedef enum logic [1:0] {
    SRC_SW_XOFF   = 2'd0,
    SRC_SW_XON    = 2'd1,
    SRC_AUTO_XOFF = 2'd2,
    SRC_AUTO_XON  = 2'd3
  } ctl_src_e;

  localparam int NUM_SRC = 4;

  function automatic logic src_is_xoff(ctl_src_e s);
    return (s == SRC_SW_XOFF) || (s == SRC_AUTO_XOFF);
  endfunction
endpackage

// File: rtl/xfc_rx_watch.sv
module xfc_rx_watch #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic [CHAR_W-1:0] xon_code,
  input  logic [CHAR_W-1:0] xoff_code,
  input  logic [1:0]        irq_clr,
  output logic              paused,
  output logic              irq_xon,
  output logic              irq_xoff
);
  logic hit_on, hit_off;

  assign hit_on  = en && rx_valid && (rx_byte == xon_code);
  assign hit_off = en && rx_valid && (rx_byte == xoff_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused   <= 1'b0;
      irq_xon  <= 1'b0;
      irq_xoff <= 1'b0;
    end else begin
      // Halt state: dropped when disabled, resume wins over halt
      if (!en)          paused <= 1'b0;
      else if (hit_on)  paused <= 1'b1 ^ 1'b1;
      else if (hit_off) paused <= 1'b1;
      // Sticky flags: a new event beats a clear in the same cycle
      irq_xon  <= hit_on  | (irq_xon  & ~irq_clr[0]);
      irq_xoff <= hit_off | (irq_xoff & ~irq_clr[1]);
    end
  end
endmodule

// File: rtl/xfc_ctl_arb.sv
module xfc_ctl_arb
  import xfc_pkg::*;
#(
  parameter int LVL_W  = 8,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  hi_thr,
  input  logic [LVL_W-1:0]  lo_thr,
  input  logic [CHAR_W-1:0] xon_code,
  input  logic [CHAR_W-1:0] xoff_code,
  input  logic              sw_xon_set,
  input  logic              sw_xoff_set,
  input  logic              ctl_ready,
  output logic              ctl_valid,
  output logic [CHAR_W-1:0] ctl_data,
  output logic              sw_xon_pend,
  output logic              sw_xoff_pend
);
  logic [NUM_SRC-1:0] req;
  logic               halted;     // last accepted character was XOFF
  logic               found;
  logic [1:0]         pick_idx;
  ctl_src_e           pick_src;
  ctl_src_e           cur_src;
  logic               grant;

  assign req[SRC_SW_XOFF]   = sw_xoff_pend;
  assign req[SRC_SW_XON]    = sw_xon_pend;
  assign req[SRC_AUTO_XOFF] = en && (level > hi_thr) && !halted;
  assign req[SRC_AUTO_XON]  = en && (level < lo_thr) && halted;

  // Fixed priority: lowest index wins
  always_comb begin
    found    = 1'b0;
    pick_idx = 2'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found    = 1'b1;
        pick_idx = 2'(i);
      end
    end
  end

  assign pick_src = ctl_src_e'(pick_idx);
  assign grant    = ctl_valid && ctl_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_valid <= 1'b0;
      ctl_data  <= '0;
      cur_src   <= SRC_SW_XOFF;
      halted    <= 1'b0;
    end else if (grant) begin
      ctl_valid <= 1'b0;
      halted    <= src_is_xoff(cur_src);
    end else if (!ctl_valid && found) begin
      ctl_valid <= 1'b1;
      cur_src   <= pick_src;
      ctl_data  <= src_is_xoff(pick_src) ? xoff_code : xon_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_xon_pend  <= 1'b0;
      sw_xoff_pend <= 1'b0;
    end else begin
      sw_xoff_pend <= sw_xoff_set |
                      (sw_xoff_pend & ~(grant && cur_src == SRC_SW_XOFF));
      sw_xon_pend  <= sw_xon_set |
                      (sw_xon_pend & ~(grant && cur_src == SRC_SW_XON));
    end
  end
endmodule

// File: rtl/xfc_tx_gate.sv
module xfc_tx_gate (
  input  logic hold,
  input  logic in_valid,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready
);
  assign out_valid = in_valid  && !hold;
  assign in_ready  = out_ready && !hold;
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
  parameter int LVL_W  = 8,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [LVL_W-1:0]  cfg_hi_thr,
  input  logic [LVL_W-1:0]  cfg_lo_thr,
  input  logic [CHAR_W-1:0] cfg_xon_code,
  input  logic [CHAR_W-1:0] cfg_xoff_code,
  input  logic              sw_xon_set,
  input  logic              sw_xoff_set,
  input  logic [1:0]        irq_clr,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_byte_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  output logic              ctl_valid,
  output logic [CHAR_W-1:0] ctl_data,
  input  logic              ctl_ready,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic              sw_xon_pend,
  output logic              sw_xoff_pend,
  output logic              irq_xon_raw,
  output logic              irq_xoff_raw,
  output logic              tx_paused
);
  xfc_ctl_arb #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (cfg_en),
    .level        (rx_level),
    .hi_thr       (cfg_hi_thr),
    .lo_thr       (cfg_lo_thr),
    .xon_code     (cfg_xon_code),
    .xoff_code    (cfg_xoff_code),
    .sw_xon_set   (sw_xon_set),
    .sw_xoff_set  (sw_xoff_set),
    .ctl_ready    (ctl_ready),
    .ctl_valid    (ctl_valid),
    .ctl_data     (ctl_data),
    .sw_xon_pend  (sw_xon_pend),
    .sw_xoff_pend (sw_xoff_pend)
  );

  xfc_rx_watch #(.CHAR_W(CHAR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .rx_valid  (rx_byte_valid),
    .rx_byte   (rx_byte),
    .xon_code  (cfg_xon_code),
    .xoff_code (cfg_xoff_code),
    .irq_clr   (irq_clr),
    .paused    (tx_paused),
    .irq_xon   (irq_xon_raw),
    .irq_xoff  (irq_xoff_raw)
  );

  xfc_tx_gate u_gate (
    .hold      (tx_paused),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready)
  );
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [CHAR_W-1:0] cfg_xoff_code,
  input logic              sw_xoff_set,
  input logic [1:0]        irq_clr,
  input logic              ctl_valid,
  input logic [CHAR_W-1:0] ctl_data,
  input logic              ctl_ready,
  input logic              tx_in_valid,
  input logic              tx_in_ready,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic              sw_xon_pend,
  input logic              sw_xoff_pend,
  input logic              irq_xon_raw,
  input logic              irq_xoff_raw,
  input logic              tx_paused
);
  p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && !ctl_ready |=> ctl_valid && $stable(ctl_data));

  p_sw_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_xoff_pend && !ctl_valid |=> sw_xoff_pend);

  p_xoff_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_xoff_pend && !ctl_valid |=> ctl_valid && ctl_data == $past(cfg_xoff_code));

  p_gate_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_paused |-> !tx_out_valid && !tx_in_ready);

  p_irq_xoff_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_xoff_raw && !irq_clr[1] |=> irq_xoff_raw);

  p_irq_xon_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_xon_raw && !irq_clr[0] |=> irq_xon_raw);

  p_off_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !tx_paused);

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && !sw_xon_pend && !sw_xoff_pend && !sw_xoff_set && !ctl_valid |=> !ctl_valid);

  p_gate_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_paused |-> (tx_out_valid == tx_in_valid) && (tx_in_ready == tx_out_ready));
endmodule

bind xonxoff_flow_ctrl xfc_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .cfg_xoff_code (cfg_xoff_code),
  .sw_xoff_set   (sw_xoff_set),
  .irq_clr       (irq_clr),
  .ctl_valid     (ctl_valid),
  .ctl_data      (ctl_data),
  .ctl_ready     (ctl_ready),
  .tx_in_valid   (tx_in_valid),
  .tx_in_ready   (tx_in_ready),
  .tx_out_valid  (tx_out_valid),
  .tx_out_ready  (tx_out_ready),
  .sw_xon_pend   (sw_xon_pend),
  .sw_xoff_pend  (sw_xoff_pend),
  .irq_xon_raw   (irq_xon_raw),
  .irq_xoff_raw  (irq_xoff_raw),
  .tx_paused     (tx_paused)
);

// File: tb/sim_xonxoff_flow_ctrl.sv
module sim_xonxoff_flow_ctrl;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;
  localparam int HI = 100;
  localparam int LO = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic [7:0] cfg_hi_thr = 8'(HI);
  logic [7:0] cfg_lo_thr = 8'(LO);
  logic [7:0] cfg_xon_code = XON;
  logic [7:0] cfg_xoff_code = XOFF;
  logic       sw_xon_set = 1'b0, sw_xoff_set = 1'b0;
  logic [1:0] irq_clr = 2'b00;
  logic [7:0] rx_level = 8'd50;
  logic       rx_byte_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ctl_valid;
  logic [7:0] ctl_data;
  logic       ctl_ready = 1'b0;
  logic       tx_in_valid = 1'b0, tx_in_ready, tx_out_valid, tx_out_ready = 1'b0;
  logic       sw_xon_pend, sw_xoff_pend, irq_xon_raw, irq_xoff_raw, tx_paused;

  int n_chk = 0;
  int n_err = 0;
  bit halted_m;

  always #5 clk = ~clk;

  xonxoff_flow_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic take(input logic [7:0] code, input string tag);
    chk(ctl_valid == 1'b1, tag, ctl_valid, 1);
    chk(ctl_data == code, tag, ctl_data, code);
    ctl_ready = 1'b1;
    tick();
    ctl_ready = 1'b0;
    chk(ctl_valid == 1'b0, "R5 drop after accept", ctl_valid, 0);
  endtask

  task automatic strobe(input logic [7:0] b);
    rx_byte = b;
    rx_byte_valid = 1'b1;
    tick();
    rx_byte_valid = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset values
    chk(ctl_valid == 0, "R1 ctl_valid", ctl_valid, 0);
    chk({sw_xon_pend, sw_xoff_pend} == 0, "R1 pend", {sw_xon_pend, sw_xoff_pend}, 0);
    chk({irq_xon_raw, irq_xoff_raw} == 0, "R1 irq", {irq_xon_raw, irq_xoff_raw}, 0);
    chk(tx_paused == 0, "R1 paused", tx_paused, 0);

    // R10 disabled: no auto char, receive ignored
    rx_level = 8'd255;
    tick(); tick(); tick();
    chk(ctl_valid == 0, "R10 no auto when off", ctl_valid, 0);
    strobe(XOFF);
    chk(tx_paused == 0, "R10 pause ignored", tx_paused, 0);
    chk(irq_xoff_raw == 0, "R10 irq ignored", irq_xoff_raw, 0);
    rx_level = 8'd50;
    tick();

    // R2 / R4 sweep of the upper threshold
    cfg_en = 1'b1;
    for (int L = 0; L < 256; L++) begin
      rx_level = 8'(L);
      tick();
      chk(ctl_valid == (L > HI), "R2 upper crossing", ctl_valid, int'(L > HI));
      if (L > HI) begin
        take(XOFF, "R2 xoff code");
        tick();
        chk(ctl_valid == 0, "R4 no repeat xoff", ctl_valid, 0);
        rx_level = 8'd0;
        tick();
        take(XON, "R3 xon after xoff");
      end
    end

    // R3 sweep of the lower threshold
    halted_m = 1'b0;
    for (int L = 0; L < 256; L++) begin
      if (!halted_m) begin
        rx_level = 8'd255;
        tick();
        take(XOFF, "R2 setup xoff");
        halted_m = 1'b1;
      end
      rx_level = 8'(L);
      tick();
      chk(ctl_valid == (L < LO), "R3 lower crossing", ctl_valid, int'(L < LO));
      if (L < LO) begin
        take(XON, "R3 xon code");
        tick();
        chk(ctl_valid == 0, "R4 no repeat xon", ctl_valid, 0);
        halted_m = 1'b0;
      end
    end
    rx_level = 8'd0;
    tick();
    take(XON, "R3 cleanup");
    rx_level = 8'd50;

    // R5 hold under back-pressure
    rx_level = 8'd255;
    tick();
    cfg_xoff_code = 8'hAA;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(ctl_valid == 1 && ctl_data == XOFF, "R5 hold", ctl_data, XOFF);
    end
    cfg_xoff_code = XOFF;
    take(XOFF, "R5 accept");
    rx_level = 8'd0;
    tick();
    take(XON, "R5 cleanup");
    rx_level = 8'd50;

    // R6 / R7 both software requests at once, auto disabled
    cfg_en = 1'b0;
    sw_xon_set = 1'b1; sw_xoff_set = 1'b1;
    tick();
    sw_xon_set = 1'b0; sw_xoff_set = 1'b0;
    chk({sw_xon_pend, sw_xoff_pend} == 2'b11, "R6 both pending", {sw_xon_pend, sw_xoff_pend}, 3);
    chk(ctl_valid == 0, "R6 not yet offered", ctl_valid, 0);
    tick();
    take(XOFF, "R7 xoff first");
    chk(sw_xoff_pend == 0 && sw_xon_pend == 1, "R6 xoff bit cleared", {sw_xon_pend, sw_xoff_pend}, 2);
    tick();
    take(XON, "R7 xon second");
    chk(sw_xon_pend == 0, "R6 xon bit cleared", sw_xon_pend, 0);

    // R7 software over automatic
    sw_xon_set = 1'b1;
    tick();
    sw_xon_set = 1'b0;
    cfg_en = 1'b1;
    rx_level = 8'd255;
    tick();
    take(XON, "R7 software beats auto");
    tick();
    take(XOFF, "R2 auto after software");
    rx_level = 8'd0;
    tick();
    take(XON, "R3 cleanup");
    rx_level = 8'd50;

    // R11 pass-through while running
    for (int c = 0; c < 4; c++) begin
      tx_in_valid = c[0]; tx_out_ready = c[1];
      #1;
      chk(tx_out_valid == c[0] && tx_in_ready == c[1], "R11 pass-through",
          {tx_out_valid, tx_in_ready}, {c[0], c[1]});
    end

    // R8 / R9 receive XOFF
    strobe(XOFF);
    chk(tx_paused == 1, "R8 halted", tx_paused, 1);
    chk(irq_xoff_raw == 1 && irq_xon_raw == 0, "R9 xoff flag", {irq_xon_raw, irq_xoff_raw}, 1);
    for (int c = 0; c < 4; c++) begin
      tx_in_valid = c[0]; tx_out_ready = c[1];
      #1;
      chk(tx_out_valid == 0 && tx_in_ready == 0, "R8 gate blocked", {tx_out_valid, tx_in_ready}, 0);
    end
    strobe(8'h41);
    tick(); tick();
    chk(tx_paused == 1, "R8 other byte keeps halt", tx_paused, 1);
    chk(irq_xoff_raw == 1, "R9 flag sticky", irq_xoff_raw, 1);
    strobe(XON);
    chk(tx_paused == 0, "R8 resumed", tx_paused, 0);
    chk(irq_xon_raw == 1, "R9 xon flag", irq_xon_raw, 1);
    irq_clr = 2'b10;
    tick();
    irq_clr = 2'b00;
    chk(irq_xoff_raw == 0 && irq_xon_raw == 1, "R9 clear one bit", {irq_xon_raw, irq_xoff_raw}, 2);
    irq_clr = 2'b01;
    strobe(XON);
    irq_clr = 2'b00;
    chk(irq_xon_raw == 1, "R9 set beats clear", irq_xon_raw, 1);
    irq_clr = 2'b01;
    tick();
    irq_clr = 2'b00;
    chk(irq_xon_raw == 0, "R9 xon cleared", irq_xon_raw, 0);

    // R10 disabling releases halt
    strobe(XOFF);
    chk(tx_paused == 1, "R8 halted again", tx_paused, 1);
    cfg_en = 1'b0;
    tick();
    chk(tx_paused == 0, "R10 release on disable", tx_paused, 0);
    tx_in_valid = 1'b1; tx_out_ready = 1'b1;
    #1;
    chk(tx_out_valid == 1 && tx_in_ready == 1, "R11 pass after release",
        {tx_out_valid, tx_in_ready}, 3);

    report();
  end
endmodule